// File: doc/BRIEF.md
# Mode-0 SPI Target Port with Status Flags

This block lets a processor take part in SPI traffic as the target device. An external controller drives the serial clock and an active-low select line. For each transfer the block shifts in one byte from the controller and shifts out one byte. The outgoing byte is the one the processor last wrote, or 0xFF when the processor has written nothing new. All serial inputs pass through synchronisers into the system clock before any edge is detected.

The processor sees two registers, chosen by `reg_sel`. The control/status register (`reg_sel`=0) holds the enable, a busy indication, three sticky event flags and three storage-only bits. The data register (`reg_sel`=1) returns the received byte on reads and takes the byte to send on writes. The interrupt request is the OR of the sticky flags, gated by an external enable input.

Top module: `spi_target_port`

## Requirements
- R1: After reset the control/status register reads 0x00, `irq` is 0 and `miso_oe` is 0.
- R2: Bit 7 of the control/status register is the busy flag. It goes to 1 once the select line falls while bit 0 (enable) is 1, and returns to 0 when the eighth bit has arrived. Processor writes to bit 7 are ignored.
- R3: Serial data uses mode 0, most significant bit first. MOSI is sampled on rising SCK and MISO changes on falling SCK. The first bit appears on MISO before the first rising edge. The byte received last is read back at `reg_sel`=1.
- R4: Bit 6 (done) is set by hardware at the end of each complete byte. It stays set until software writes 0 to it.
- R5: A data-register read clears the pending-data condition. If a byte completes while a previous byte is still pending, bit 5 (overrun) is set, the new byte is dropped and the old byte stays readable.
- R6: A data-register write while busy sets bit 4 (collision). The byte being shifted is unaffected and the written value is discarded.
- R7: Writing 1 to bit 6, 5 or 4 sets that flag, exactly as a hardware event would.
- R8: If the select line rises before eight bits have arrived, busy clears, done stays 0 and the data register is unchanged.
- R9: With bit 0 at 0, a select-line fall starts no transfer, busy stays 0 and `miso_oe` stays 0.
- R10: Bits 3, 2 and 1 read back what was written and have no effect on transfers.
- R11: When no byte has been written since the previous transfer started, the block transmits 0xFF.
- R12: `irq` equals `irq_en` AND (done OR overrun OR collision).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | 0 selects control/status, 1 selects data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| sck | input | 1 | Serial clock from the controller |
| cs_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for MISO; MISO is high-impedance when this is 0 |

## Verification
The hardest state to reach is a data-register write that lands in the middle of a byte. The bench produces it by splitting the transfer into two bit-banged halves with a bus write between them. It then checks the bits shifted out after the write and the byte sent in the following transfer. Overrun is reached by running two complete transfers with no read between them. An aborted transfer is produced by raising the select line after three clock pulses.

// File: rtl/spi_target_port.sv
module spi_target_port #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_sel,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         irq_en,
  output logic         irq,
  input  logic         sck,
  input  logic         cs_n,
  input  logic         mosi,
  output logic         miso,
  output logic         miso_oe
);
  localparam int CW = $clog2(W);

  logic [SYNC:0] sck_p, cs_p, mosi_p;
  logic en, mstm, modfe, modf, wcol, rovr, done, busy;
  logic unread, tx_pend;
  logic [CW-1:0] cnt;
  logic [W-1:0] tx_sh, rx_sh, tx_buf, rx_buf;

  wire sck_rise = sck_p[SYNC-1] & ~sck_p[SYNC];
  wire sck_fall = ~sck_p[SYNC-1] & sck_p[SYNC];
  wire cs_hi    = cs_p[SYNC-1];
  wire cs_fall  = ~cs_p[SYNC-1] & cs_p[SYNC];
  wire mosi_s   = mosi_p[SYNC-1];
  wire wr_ctrl  = wr_en & ~reg_sel;
  wire wr_data  = wr_en & reg_sel;
  wire rd_data  = rd_en & reg_sel;
  wire done_evt = en & busy & ~cs_hi & sck_rise & (cnt == CW'(W-1));
  wire [W-1:0] rx_next = {rx_sh[W-2:0], mosi_s};

  assign rdata   = reg_sel ? rx_buf : {busy, done, rovr, wcol, modf, modfe, mstm, en};
  assign irq     = irq_en & (done | rovr | wcol);
  assign miso    = tx_sh[W-1];
  assign miso_oe = busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p  <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[SYNC-1:0], sck};
      cs_p   <= {cs_p[SYNC-1:0], cs_n};
      mosi_p <= {mosi_p[SYNC-1:0], mosi};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {en, mstm, modfe, modf, wcol, rovr, done, busy} <= '0;
      unread  <= 1'b0;
      tx_pend <= 1'b0;
      cnt     <= '0;
      tx_sh   <= '1;
      rx_sh   <= '0;
      tx_buf  <= '0;
      rx_buf  <= '0;
    end else begin
      if (wr_ctrl) begin
        en    <= wdata[0];
        mstm  <= wdata[1];
        modfe <= wdata[2];
        modf  <= wdata[3];
        wcol  <= wdata[4];
        rovr  <= wdata[5];
        done  <= wdata[6];
      end
      if (rd_data) unread <= 1'b0;
      if (wr_data) begin
        if (busy) wcol <= 1'b1;
        else begin
          tx_buf  <= wdata;
          tx_pend <= 1'b1;
        end
      end
      if (!en) busy <= 1'b0;
      else if (busy && cs_hi) busy <= 1'b0;
      else if (!busy && cs_fall) begin
        busy    <= 1'b1;
        cnt     <= '0;
        tx_sh   <= tx_pend ? tx_buf : '1;
        tx_pend <= 1'b0;
      end else if (busy && sck_rise) begin
        rx_sh <= rx_next;
        cnt   <= cnt + 1'b1;
        if (done_evt) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (unread && !rd_data) rovr <= 1'b1;
          else begin
            rx_buf <= rx_next;
            unread <= 1'b1;
          end
        end
      end else if (busy && sck_fall) tx_sh <= {tx_sh[W-2:0], 1'b1};
    end

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !busy && cs_fall && !wr_ctrl) |=> busy);
  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cs_hi) |=> !busy);
  // R5
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && unread && !rd_data) |=> (rovr && $stable(rx_buf)));
  // R6
  wcol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && busy) |=> (wcol && $stable(tx_buf)));
  // R9
  off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !miso_oe);
endmodule

// File: tb/test_spi_target_port.sv
module test_spi_target_port;
  logic clk = 0, rst_n = 0;
  logic reg_sel = 0, wr_en = 0, rd_en = 0, irq_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq, miso, miso_oe;
  logic sck = 0, cs_n = 1, mosi = 0;
  int tests = 0, fails = 0, cyc = 0;

  spi_target_port i_spi_target_port (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); reg_sel = sel; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    @(negedge clk); reg_sel = sel; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_set(input logic v);
    @(negedge clk); cs_n = v; wait_n(8);
  endtask

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] got);
    got = 0;
    for (int i = 0; i < n; i++) begin
      mosi = tx[7-i];
      wait_n(6);
      got = {got[6:0], miso};
      sck = 1; wait_n(8);
      sck = 0; wait_n(8);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] got);
    cs_set(0); bits(tx, 8, got); cs_set(1);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(0, d); check("R1 ctrl", d, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 miso_oe", {7'b0, miso_oe}, 8'h00);
  endtask

  task automatic t_modefault;
    logic [7:0] d, g;
    wr(0, 8'h0F); rd(0, d); check("R10 readback", d, 8'h0F);
    wr(1, 8'hC3); xfer(8'h96, g);
    check("R10 tx ok", g, 8'hC3);
    rd(1, d); check("R10 rx ok", d, 8'h96);
    rd(0, d); check("R10 ctrl after", d, 8'h4F);
    wr(0, 8'h01);
  endtask

  task automatic t_basic;
    logic [7:0] d, g;
    wr(1, 8'hA5); xfer(8'h3C, g);
    check("R3 miso byte", g, 8'hA5);
    rd(0, d); check("R4 done set", d, 8'h41);
    check("R12 irq gated", {7'b0, irq}, 8'h00);
    rd(1, d); check("R3 rx byte", d, 8'h3C);
    rd(0, d); check("R4 done sticky", d, 8'h41);
    wr(0, 8'h01); rd(0, d); check("R4 done cleared", d, 8'h01);
    xfer(8'h00, g); check("R11 idle 0xFF", g, 8'hFF);
    rd(1, d); wr(0, 8'h01);
  endtask

  task automatic t_busy;
    logic [7:0] d, g;
    cs_set(0);
    rd(0, d); check("R2 busy set", d, 8'h81);
    check("R9 oe while busy", {7'b0, miso_oe}, 8'h01);
    wr(0, 8'h01); rd(0, d); check("R2 busy not writable", d, 8'h81);
    bits(8'h5A, 8, g);
    rd(0, d); check("R2 busy cleared at 8th bit", d, 8'h41);
    cs_set(1);
    rd(1, d); check("R3 rx 5A", d, 8'h5A);
    wr(0, 8'h01);
  endtask

  task automatic t_overrun;
    logic [7:0] d, g;
    xfer(8'h11, g); xfer(8'h22, g);
    rd(0, d); check("R5 overrun flag", d, 8'h61);
    rd(1, d); check("R5 old byte kept", d, 8'h11);
    wr(0, 8'h01);
    xfer(8'h33, g);
    rd(0, d); check("R5 no overrun after read", d, 8'h41);
    rd(1, d); check("R5 new byte", d, 8'h33);
    wr(0, 8'h01);
  endtask

  task automatic t_wcol;
    logic [7:0] d, g1, g2;
    wr(1, 8'h5A);
    cs_set(0); bits(8'h00, 4, g1);
    wr(1, 8'h99);
    rd(0, d); check("R6 collision flag", d, 8'h91);
    bits(8'h00, 4, g2); cs_set(1);
    check("R6 shift unaffected", {g1[3:0], g2[3:0]}, 8'h5A);
    xfer(8'h00, g1); check("R6 write discarded", g1, 8'hFF);
    rd(1, d); wr(0, 8'h01);
  endtask

  task automatic t_abort;
    logic [7:0] d, g;
    rd(1, d);
    cs_set(0); bits(8'hF0, 3, g); cs_set(1);
    rd(0, d); check("R8 aborted status", d, 8'h01);
    rd(1, d); check("R8 data unchanged", d, 8'h00);
  endtask

  task automatic t_disabled;
    logic [7:0] d, g;
    wr(0, 8'h00);
    cs_set(0);
    check("R9 oe off", {7'b0, miso_oe}, 8'h00);
    rd(0, d); check("R9 not busy", d, 8'h00);
    bits(8'hE7, 8, g); cs_set(1);
    rd(0, d); check("R9 no done", d, 8'h00);
    rd(1, d); check("R9 data unchanged", d, 8'h00);
    wr(0, 8'h01);
  endtask

  task automatic t_swflags;
    logic [7:0] d;
    logic [7:0] m [3] = '{8'h41, 8'h21, 8'h11};
    wr(0, 8'h71); rd(0, d); check("R7 sw set", d, 8'h71);
    check("R12 irq off when disabled", {7'b0, irq}, 8'h00);
    irq_en = 1;
    for (int i = 0; i < 3; i++) begin
      wr(0, m[i]); #1 check("R7 flag irq", {7'b0, irq}, 8'h01);
      wr(0, 8'h01); #1 check("R12 irq clear", {7'b0, irq}, 8'h00);
    end
    irq_en = 0;
  endtask

  initial begin
    wait_n(3); rst_n = 1; wait_n(2);
    t_reset;
    t_modefault;
    t_basic;
    t_busy;
    t_overrun;
    t_wcol;
    t_abort;
    t_disabled;
    t_swflags;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule